// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Tag Store with Victim Writeback

This block holds the tags and line state for a direct-mapped, write-back first-level data cache. A lookup selects its set from virtual address bits, so it can start while the address translation runs in parallel. One cycle later the block reports whether the line is present by comparing the stored tag with the translated physical frame number. The data array, the translation buffer and the refill sequencing all sit outside this block.

Lines are 32 bytes and pages are 4 KiB. The set index is taken from address bits 12:5. Bit 12 lies above the page offset, so translation can change it. For that reason the stored tag covers every physical bit above the page offset (bits 35:12), which includes index bit 12. Because of that overlap, the line address of a dirty victim can be rebuilt from the stored tag and the in-page index bits alone. No translation result is needed, however long ago the store was made. The block also reports a possible synonym: a miss whose physical frame is valid in the partner set, which differs from the looked-up set only in its top index bit.

Back-pressure works as follows. A refill is accepted only while no victim is waiting. A victim stays on the writeback port, with its address unchanged, until the consumer takes it. A lookup is held off in any cycle in which a refill is offered.

Top module: `vipt_tag_unit`

## Requirements
- R1: After reset every line is invalid, so any lookup misses. After reset `wb_valid` and `rsp_valid` are 0, and `req_ready` and `fill_ready` are 1.
- R2: A lookup is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for exactly the cycle after each accepted lookup and 0 otherwise. `req_ready` is 0 in any cycle where `fill_valid` is 1.
- R3: The set index is virtual address bits 12:5. `rsp_hit` is 1 only when the selected line is valid and its stored tag equals `req_pfn`, which is physical address bits 35:12.
- R4: An accepted refill writes `fill_pfn` as the tag of set `fill_vaddr[12:5]` and leaves that line valid and clean. `fill_ready` is 0 while a victim is pending.
- R5: A store that hits marks the line dirty. A load hit does not change line state. A store miss does not change line state.
- R6: A refill that replaces a valid dirty line raises `wb_valid` in the next cycle. The victim address is {old tag, index bits 11:5, 5'b0}. A refill that replaces a clean or invalid line raises no writeback.
- R7: Once `wb_valid` is 1 it stays 1, with `wb_addr` unchanged, until a cycle in which `wb_ready` is 1. After that cycle it drops.
- R8: `rsp_synonym` is 1 when the lookup missed and the set whose index differs only in bit 7 of the index (address bit 12) holds a valid line whose tag equals `req_pfn`. `rsp_synonym` is never 1 together with `rsp_hit`.
- R9: Virtual address bits above bit 12 and the line offset bits 4:0 have no effect on which set a lookup uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup offered |
| req_ready | output | 1 | Lookup can be accepted |
| req_vaddr | input | VA_W (40) | Virtual address of the lookup |
| req_pfn | input | TAG_W (24) | Translated frame number, physical bits 35:12 |
| req_store | input | 1 | Lookup is a store |
| rsp_valid | output | 1 | Lookup result present this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_synonym | output | 1 | Miss whose frame is valid in the partner set |
| fill_valid | input | 1 | Refill offered |
| fill_ready | output | 1 | Refill can be accepted |
| fill_vaddr | input | VA_W (40) | Virtual address selecting the refilled set |
| fill_pfn | input | TAG_W (24) | Tag written by the refill |
| wb_valid | output | 1 | Dirty victim waiting to be written back |
| wb_ready | input | 1 | Writeback consumer takes the victim |
| wb_addr | output | PA_W (36) | Physical line address of the victim |

## Verification
The bench builds the block with its default parameters: a 40-bit virtual address, a 36-bit physical address, 4 KiB pages, 32-byte lines and 256 sets. With these values exactly one index bit lies above the page offset. That brings two cases within reach: partner sets that differ only in address bit 12, where synonyms are flagged, and victim addresses whose bit 12 comes from the tag rather than from the virtual index. The stimulus includes the highest set, so the all-ones tag and index produce a victim address with every upper bit set.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // Number of index bits that lie above the page offset.
  localparam int ABOVE_PAGE_BITS = 1;

  typedef struct packed {
    logic valid;
    logic dirty;
  } line_flags_t;
endpackage

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        look_idx,
  output logic [TAG_W-1:0]        look_tag,
  output vipt_pkg::line_flags_t   look_fl,
  input  logic [IDX_W-1:0]        alias_idx,
  output logic [TAG_W-1:0]        alias_tag,
  output vipt_pkg::line_flags_t   alias_fl,
  input  logic                    fill_en,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [TAG_W-1:0]        fill_tag,
  output logic [TAG_W-1:0]        victim_tag,
  output vipt_pkg::line_flags_t   victim_fl,
  input  logic                    mark_en,
  input  logic [IDX_W-1:0]        mark_idx
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0]      tag_mem [SETS];
  vipt_pkg::line_flags_t fl_q    [SETS];

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fl_q[s] <= '0;
      end else if (fill_en && fill_idx == IDX_W'(s)) begin
        fl_q[s].valid <= 1'b1;
        fl_q[s].dirty <= 1'b0;
      end else if (mark_en && mark_idx == IDX_W'(s)) begin
        fl_q[s].dirty <= 1'b1;
      end
    end
  end

  assign look_tag   = tag_mem[look_idx];
  assign look_fl    = fl_q[look_idx];
  assign alias_tag  = tag_mem[alias_idx];
  assign alias_fl   = fl_q[alias_idx];
  assign victim_tag = tag_mem[fill_idx];
  assign victim_fl  = fl_q[fill_idx];

  // R2: lookups are held off while a refill is offered, so no dirty mark meets a fill
  p_no_fill_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && mark_en));
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [IDX_W-1:0]      idx,
  input  logic [TAG_W-1:0]      pfn,
  input  logic                  store,
  output logic [IDX_W-1:0]      alias_idx,
  input  logic [TAG_W-1:0]      look_tag,
  input  vipt_pkg::line_flags_t look_fl,
  input  logic [TAG_W-1:0]      alias_tag,
  input  vipt_pkg::line_flags_t alias_fl,
  output logic                  mark_en,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_synonym
);
  logic hit_c, syn_c;
  logic valid_q, hit_q, syn_q;

  // Partner set: index with its top (above-page) bit flipped.
  assign alias_idx = {~idx[IDX_W-1], idx[IDX_W-2:0]};

  assign hit_c   = look_fl.valid && (look_tag == pfn);
  assign syn_c   = !hit_c && alias_fl.valid && (alias_tag == pfn);
  assign mark_en = accept && store && hit_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      syn_q   <= 1'b0;
    end else begin
      valid_q <= accept;
      hit_q   <= accept && hit_c;
      syn_q   <= accept && syn_c;
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_hit     = hit_q;
  assign rsp_synonym = syn_q;

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_rsp_only_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);
  p_syn_not_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_synonym));
endmodule

// File: rtl/vipt_victim_buf.sv
module vipt_victim_buf #(
  parameter int TAG_W      = 24,
  parameter int INPG_W     = 7,
  parameter int LINE_OFF_W = 5,
  parameter int PA_W       = 36
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_fire,
  input  logic [TAG_W-1:0]      victim_tag,
  input  vipt_pkg::line_flags_t victim_fl,
  input  logic [INPG_W-1:0]     idx_in_page,
  input  logic                  wb_ready,
  output logic                  wb_valid,
  output logic [PA_W-1:0]       wb_addr
);
  logic            pend_q;
  logic [PA_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (pend_q && wb_ready) pend_q <= 1'b0;
      if (fill_fire && victim_fl.valid && victim_fl.dirty) begin
        pend_q <= 1'b1;
        // Tag already carries the above-page index bit; no translation needed.
        addr_q <= {victim_tag, idx_in_page, {LINE_OFF_W{1'b0}}};
      end
    end
  end

  assign wb_valid = pend_q;
  assign wb_addr  = addr_q;

  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));
  p_wb_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> !wb_valid);
  p_wb_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_addr[LINE_OFF_W-1:0] == '0));
  p_no_overwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |-> !wb_valid);
endmodule

// File: rtl/vipt_tag_unit.sv
module vipt_tag_unit #(
  parameter int VA_W       = 40,
  parameter int PA_W       = 36,
  parameter int PAGE_OFF_W = 12,
  parameter int LINE_OFF_W = 5,
  localparam int TAG_W     = PA_W - PAGE_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [TAG_W-1:0]  req_pfn,
  input  logic              req_store,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_synonym,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [TAG_W-1:0]  fill_pfn,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [PA_W-1:0]   wb_addr
);
  localparam int INPG_W = PAGE_OFF_W - LINE_OFF_W;
  localparam int IDX_W  = INPG_W + vipt_pkg::ABOVE_PAGE_BITS;
  localparam int IDX_HI = LINE_OFF_W + IDX_W;

  logic                  accept, fill_fire, mark_en;
  logic [IDX_W-1:0]      look_idx, alias_idx, fill_idx;
  logic [TAG_W-1:0]      look_tag, alias_tag, victim_tag;
  vipt_pkg::line_flags_t look_fl, alias_fl, victim_fl;
  logic                  vaddr_unused;

  assign req_ready  = !fill_valid;
  assign fill_ready = !wb_valid;
  assign accept     = req_valid && req_ready;
  assign fill_fire  = fill_valid && fill_ready;

  assign look_idx = req_vaddr[LINE_OFF_W +: IDX_W];
  assign fill_idx = fill_vaddr[LINE_OFF_W +: IDX_W];
  assign vaddr_unused = ^{req_vaddr[VA_W-1:IDX_HI], req_vaddr[LINE_OFF_W-1:0],
                          fill_vaddr[VA_W-1:IDX_HI], fill_vaddr[LINE_OFF_W-1:0]};

  vipt_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .look_idx(look_idx), .look_tag(look_tag), .look_fl(look_fl),
    .alias_idx(alias_idx), .alias_tag(alias_tag), .alias_fl(alias_fl),
    .fill_en(fill_fire), .fill_idx(fill_idx), .fill_tag(fill_pfn),
    .victim_tag(victim_tag), .victim_fl(victim_fl),
    .mark_en(mark_en), .mark_idx(look_idx)
  );

  vipt_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .idx(look_idx), .pfn(req_pfn), .store(req_store),
    .alias_idx(alias_idx),
    .look_tag(look_tag), .look_fl(look_fl),
    .alias_tag(alias_tag), .alias_fl(alias_fl),
    .mark_en(mark_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_synonym(rsp_synonym)
  );

  vipt_victim_buf #(.TAG_W(TAG_W), .INPG_W(INPG_W), .LINE_OFF_W(LINE_OFF_W),
                    .PA_W(PA_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_fire(fill_fire),
    .victim_tag(victim_tag), .victim_fl(victim_fl),
    .idx_in_page(fill_idx[INPG_W-1:0]),
    .wb_ready(wb_ready), .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  p_req_held_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_ready);
  p_fill_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !fill_ready);
endmodule

// File: tb/vipt_tag_unit_tb_top.sv
module vipt_tag_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_store = 0, fill_valid = 0, wb_ready = 0;
  logic [39:0] req_vaddr = '0, fill_vaddr = '0;
  logic [23:0] req_pfn = '0, fill_pfn = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_synonym, fill_ready, wb_valid;
  logic [35:0] wb_addr;

  vipt_tag_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_pfn(req_pfn), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_synonym(rsp_synonym),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vaddr(fill_vaddr),
    .fill_pfn(fill_pfn), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr)
  );

  int total = 0, fails = 0, cyc = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]  op;   // 0 load, 1 store, 2 refill
    logic [39:0] va;
    logic [23:0] pfn;
    logic        hit;
    logic        syn;
    logic        wb;
    logic [35:0] wa;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 40'h00_0000_1040, 24'hABCDE1, 1'b0, 1'b0, 1'b0, 36'h0},          // R1 cold miss
    '{2'd2, 40'h00_0000_1040, 24'hABCDE1, 1'b0, 1'b0, 1'b0, 36'h0},          // R4
    '{2'd0, 40'h00_0000_1040, 24'hABCDE1, 1'b1, 1'b0, 1'b0, 36'h0},          // R3 hit
    '{2'd0, 40'h00_0000_1040, 24'hABCDE0, 1'b0, 1'b0, 1'b0, 36'h0},          // R3 tag differs
    '{2'd0, 40'h00_0000_0040, 24'hABCDE1, 1'b0, 1'b1, 1'b0, 36'h0},          // R8 synonym
    '{2'd1, 40'h00_0000_1040, 24'hABCDE1, 1'b1, 1'b0, 1'b0, 36'h0},          // R5 store hit
    '{2'd2, 40'h00_0000_1040, 24'h123456, 1'b0, 1'b0, 1'b1, 36'hABCDE1040},  // R6 dirty victim
    '{2'd0, 40'h00_0000_1040, 24'h123456, 1'b1, 1'b0, 1'b0, 36'h0},          // R5 load hit
    '{2'd2, 40'h00_0000_1040, 24'h654321, 1'b0, 1'b0, 1'b0, 36'h0},          // R5/R6 clean
    '{2'd0, 40'hFF_FFFF_F05F, 24'h654321, 1'b1, 1'b0, 1'b0, 36'h0},          // R9
    '{2'd1, 40'h00_0000_0040, 24'h777777, 1'b0, 1'b0, 1'b0, 36'h0},          // R5 store miss
    '{2'd2, 40'h00_0000_0040, 24'h777777, 1'b0, 1'b0, 1'b0, 36'h0},          // R6 invalid
    '{2'd2, 40'h00_0000_0040, 24'h888888, 1'b0, 1'b0, 1'b0, 36'h0},          // R5 still clean
    '{2'd1, 40'h00_0000_0040, 24'h888888, 1'b1, 1'b0, 1'b0, 36'h0},
    '{2'd2, 40'h00_0000_0040, 24'h999999, 1'b0, 1'b0, 1'b1, 36'h888888040},
    '{2'd0, 40'h00_0000_1040, 24'h999999, 1'b0, 1'b1, 1'b0, 36'h0},          // R8
    '{2'd2, 40'h00_0000_1FE0, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 36'h0},          // top set
    '{2'd1, 40'h00_0000_1FE0, 24'hFFFFFF, 1'b1, 1'b0, 1'b0, 36'h0},
    '{2'd2, 40'h00_0000_1FE0, 24'h000000, 1'b0, 1'b0, 1'b1, 36'hFFFFFFFE0}
  };

  logic got_hit, got_syn;

  task automatic lookup(input logic [39:0] va, input logic [23:0] pfn, input logic st);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_pfn = pfn; req_store = st;
    @(negedge clk);
    req_valid = 0; req_store = 0;
    chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    got_hit = rsp_hit; got_syn = rsp_synonym;
  endtask

  task automatic refill(input logic [39:0] va, input logic [23:0] pfn);
    @(negedge clk);
    chk("R4 fill_ready", 64'(fill_ready), 64'd1);
    fill_valid = 1; fill_vaddr = va; fill_pfn = pfn;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    wb_ready = 1;
    @(negedge clk);
    wb_ready = 0;
    chk("R7 wb drops", 64'(wb_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 wb_valid", 64'(wb_valid), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 fill_ready", 64'(fill_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 2'd2) begin
        refill(VECS[i].va, VECS[i].pfn);
        chk("R6 wb_valid", 64'(wb_valid), 64'(VECS[i].wb));
        if (VECS[i].wb) begin
          chk("R6 wb_addr", 64'(wb_addr), 64'(VECS[i].wa));
          drain();
        end
      end else begin
        lookup(VECS[i].va, VECS[i].pfn, VECS[i].op[0]);
        chk("R3 hit", 64'(got_hit), 64'(VECS[i].hit));
        chk("R8 synonym", 64'(got_syn), 64'(VECS[i].syn));
      end
    end

    // R2: response is a single-cycle pulse
    lookup(40'h00_0000_1040, 24'h654321, 1'b0);
    @(negedge clk);
    chk("R2 rsp pulse", 64'(rsp_valid), 64'd0);

    // R9: high virtual bits and line offset ignored for set selection
    lookup(40'h12_3456_705F, 24'h654321, 1'b0);
    chk("R9 hit", 64'(got_hit), 64'd1);

    // R5: load hit leaves the line clean
    refill(40'h00_0000_1FE0, 24'h111111);
    chk("R5 no wb", 64'(wb_valid), 64'd0);
    lookup(40'h00_0000_1FE0, 24'h111111, 1'b0);
    refill(40'h00_0000_1FE0, 24'h222222);
    chk("R5 load hit clean", 64'(wb_valid), 64'd0);

    // R7 / R4 / R2: held victim and back-pressure
    lookup(40'h00_0000_0040, 24'h999999, 1'b1);
    chk("R5 store hit", 64'(got_hit), 64'd1);
    refill(40'h00_0000_0040, 24'hAAAAAA);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 wb held", 64'(wb_valid), 64'd1);
      chk("R7 wb_addr stable", 64'(wb_addr), 64'h999999040);
    end
    fill_valid = 1; fill_vaddr = 40'h0; fill_pfn = 24'h0;
    #1;
    chk("R4 fill_ready low", 64'(fill_ready), 64'd0);
    chk("R2 req_ready low", 64'(req_ready), 64'd0);
    @(negedge clk);
    fill_valid = 0;
    drain();

    // R1: reset mid-run invalidates everything
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 wb after reset", 64'(wb_valid), 64'd0);
    rst_n = 1;
    lookup(40'h00_0000_0040, 24'hAAAAAA, 1'b0);
    chk("R1 miss after reset", 64'(got_hit), 64'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule